// File: doc/BRIEF.md
# Conditional Data-Processing ALU with Status Flags

This block executes one 32-bit register-to-register or register-to-immediate data-processing operation per clock. The operation is selected by a 4-bit opcode. It is gated by a 4-bit condition field, which is evaluated against the four status flags the block holds (negative, zero, carry, overflow). When the condition holds, the result is registered. A one-cycle destination write-enable pulse accompanies the result if the operation writes a destination. The flags are rewritten when the set-flags bit is high.

Operand A can be replaced by the address of the current instruction plus a fixed pipeline offset of 8. Reversed subtracts exchange the operands before the subtraction. Carry acts as the carry-in for add-with-carry. Carry acts as an inverted borrow for the subtract-with-carry forms. Logical operations touch only N and Z. They leave V alone. They change C only when an immediate operand was produced by rotation.

All results appear one clock after the operation is presented. The next operation already sees the flags written by the previous one.

Top module: `dp_alu_core`

## Requirements
- R1: Opcodes map to results as follows. 0 A&B, 1 A^B, 2 A-B, 3 B-A, 4 A+B, 5 A+B+C, 6 A-B-!C, 7 B-A-!C, 12 A|B, 13 B, 14 A&~B, 15 ~B. A committed writing operation drives `res_data` and a one-cycle `res_we` pulse at the next rising edge. `res_data` holds its value otherwise.
- R2: Opcodes 8 (AND test), 9 (XOR test), 10 (subtract compare) and 11 (add compare) compute the same results as 0, 1, 2 and 4 respectively. They only update flags: `res_we` stays low and `res_data` is unchanged.
- R3: Opcodes 3 and 7 swap the operands. Opcode 5 adds the C flag as carry-in. Opcodes 6 and 7 subtract one more when C is 0.
- R4: With set-flags high, add-type operations (4, 5, 11) set C to the carry out of bit 31. Subtract-type operations (2, 3, 6, 7, 10) set C when the unsigned minuend is at least the subtrahend plus the borrow, compared without truncation.
- R5: With set-flags high, arithmetic operations set V when the signed result of the operation does not fit in 32 bits.
- R6: `flags_q` is {N,Z,C,V} with N at bit 3 and V at bit 0. With set-flags high, every committed operation sets Z when the 32-bit result is zero and sets N to result bit 31.
- R7: Logical operations (0, 1, 8, 9, 12–15) with set-flags high keep V. They keep C, except in immediate form when the rotated indicator is high or B exceeds 255; in that case C takes B bit 31.
- R8: Condition codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 !(!Z&(N==V)), 14 always, 15 never.
- R9: When valid is low or the condition fails, neither the result, the write-enable nor the flags change. Flags change only when set-flags is high.
- R10: With the PC-select input high, operand A is replaced by `in_pc` + 8. This holds for reversed subtracts too, where the replaced operand becomes the subtrahend.
- R11: Synchronous active-low reset clears `flags_q`, `res_data` and `res_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_opcode | input | 4 | Operation select (R1) |
| in_set_flags | input | 1 | Update flags when committed |
| in_imm_form | input | 1 | Operand B is an immediate |
| in_cond | input | 4 | Condition code (R8) |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Second operand or immediate |
| in_imm_rot | input | 1 | Immediate was produced by rotation |
| in_pc_sel | input | 1 | Use instruction address + 8 as operand A |
| in_pc | input | 32 | Address of the current instruction |
| res_data | output | 32 | Registered result |
| res_we | output | 1 | Destination write-enable pulse |
| flags_q | output | 4 | Status flags {N,Z,C,V} |

## Verification
The assertions expect the control inputs to be at known values on every clock edge outside reset; the stimulus never drives X. The assertions rely on opcodes with upper bits `10` being exactly the non-writing class. They also rely on a failed condition, an idle cycle or a cleared set-flags bit freezing the flags regardless of operand values. The stimulus therefore mixes all sixteen condition codes with random and boundary operands (zero, all ones, the signed extremes), and toggles valid and set-flags freely. It keeps the PC operand and the rotated indicator within their defined meaning, so that every antecedent is reached under legal input combinations.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [1:0] {CLS_LOGIC, CLS_ADD, CLS_SUB} dp_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } dp_flags_t;

  function automatic dp_class_e op_class(dp_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_CMN:                 return CLS_ADD;
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return CLS_SUB;
      default:                                return CLS_LOGIC;
    endcase
  endfunction

  // Test/compare group never writes a destination.
  function automatic logic op_writes(dp_op_e op);
    return op[3:2] != 2'b10;
  endfunction

  function automatic logic op_swaps(dp_op_e op);
    return (op == OP_RSB) || (op == OP_RSC);
  endfunction

  function automatic logic op_uses_flag_carry(dp_op_e op);
    return (op == OP_ADC) || (op == OP_SBC) || (op == OP_RSC);
  endfunction

endpackage

// File: rtl/dp_cond_check.sv
module dp_cond_check
  import dp_alu_pkg::*;
(
  input  logic [3:0] cond,
  input  dp_flags_t  flags,
  output logic       pass
);
  logic base;

  // Even code tests the predicate, odd code its inverse; pair 7 is always/never.
  always_comb begin
    case (cond[3:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = (flags.n == flags.v);
      3'd6:    base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
    pass = base ^ cond[0];
  end
endmodule

// File: rtl/dp_operand_sel.sv
module dp_operand_sel #(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] pc,
  input  logic              pc_sel,
  input  logic              swap,
  output logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] PC_ADJ = DATA_W'(PC_OFFSET);

  logic [DATA_W-1:0] first_src;

  always_comb begin
    first_src = pc_sel ? (pc + PC_ADJ) : opa;
    x = swap ? opb : first_src;
    y = swap ? first_src : opb;
  end
endmodule

// File: rtl/dp_alu_exec.sv
module dp_alu_exec
  import dp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dp_op_e            op,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              flag_c,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add_cin(logic [DATA_W-1:0] p,
                                              logic [DATA_W-1:0] q,
                                              logic cin);
    return {1'b0, p} + {1'b0, q} + {{DATA_W{1'b0}}, cin};
  endfunction

  function automatic logic sign_ovf(logic pm, logic qm, logic rm);
    return (pm == qm) && (rm != pm);
  endfunction

  dp_class_e         cls;
  logic              cin;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   wide;

  always_comb begin
    cls    = op_class(op);
    addend = (cls == CLS_SUB) ? ~y : y;
    if (op_uses_flag_carry(op)) cin = flag_c;
    else                        cin = (cls == CLS_SUB);
    wide   = add_cin(x, addend, cin);

    case (op)
      OP_AND, OP_TST: result = x & y;
      OP_EOR, OP_TEQ: result = x ^ y;
      OP_ORR:         result = x | y;
      OP_MOV:         result = y;
      OP_BIC:         result = x & ~y;
      OP_MVN:         result = ~y;
      default:        result = wide[MSB:0];
    endcase

    carry_out = wide[DATA_W];
    ovf       = sign_ovf(x[MSB], addend[MSB], wide[MSB]);
  end
endmodule

// File: rtl/dp_flag_next.sv
module dp_flag_next
  import dp_alu_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int IMM_PLAIN_MAX = 255
) (
  input  dp_op_e            op,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_out,
  input  logic              ovf,
  input  dp_flags_t         cur,
  input  logic              imm_form,
  input  logic              imm_rot,
  input  logic [DATA_W-1:0] opb,
  output dp_flags_t         nxt
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] PLAIN_LIMIT = DATA_W'(IMM_PLAIN_MAX);

  logic rotated_imm;

  always_comb begin
    rotated_imm = imm_form && (imm_rot || (opb > PLAIN_LIMIT));
    nxt.n = result[MSB];
    nxt.z = (result == '0);
    if (op_class(op) == CLS_LOGIC) begin
      nxt.v = cur.v;
      nxt.c = rotated_imm ? opb[MSB] : cur.c;
    end else begin
      nxt.v = ovf;
      nxt.c = carry_out;
    end
  end
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int PC_OFFSET     = 8,
  parameter int IMM_PLAIN_MAX = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_opcode,
  input  logic              in_set_flags,
  input  logic              in_imm_form,
  input  logic [3:0]        in_cond,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic              in_imm_rot,
  input  logic              in_pc_sel,
  input  logic [DATA_W-1:0] in_pc,
  output logic [DATA_W-1:0] res_data,
  output logic              res_we,
  output logic [3:0]        flags_q
);
  dp_op_e            op;
  dp_flags_t         flags_cur;
  dp_flags_t         flags_nx;
  logic              cond_pass;
  logic              commit;
  logic              wr_dest;
  logic [DATA_W-1:0] op_x;
  logic [DATA_W-1:0] op_y;
  logic [DATA_W-1:0] alu_result;
  logic              alu_carry;
  logic              alu_ovf;

  assign op        = dp_op_e'(in_opcode);
  assign flags_cur = dp_flags_t'(flags_q);
  assign commit    = in_valid & cond_pass;
  assign wr_dest   = commit & op_writes(op);

  dp_cond_check u_cond (
    .cond  (in_cond),
    .flags (flags_cur),
    .pass  (cond_pass)
  );

  dp_operand_sel #(.DATA_W(DATA_W), .PC_OFFSET(PC_OFFSET)) u_opsel (
    .opa    (in_opa),
    .opb    (in_opb),
    .pc     (in_pc),
    .pc_sel (in_pc_sel),
    .swap   (op_swaps(op)),
    .x      (op_x),
    .y      (op_y)
  );

  dp_alu_exec #(.DATA_W(DATA_W)) u_exec (
    .op        (op),
    .x         (op_x),
    .y         (op_y),
    .flag_c    (flags_cur.c),
    .result    (alu_result),
    .carry_out (alu_carry),
    .ovf       (alu_ovf)
  );

  dp_flag_next #(.DATA_W(DATA_W), .IMM_PLAIN_MAX(IMM_PLAIN_MAX)) u_fnext (
    .op        (op),
    .result    (alu_result),
    .carry_out (alu_carry),
    .ovf       (alu_ovf),
    .cur       (flags_cur),
    .imm_form  (in_imm_form),
    .imm_rot   (in_imm_rot),
    .opb       (in_opb),
    .nxt       (flags_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data <= '0;
      res_we   <= 1'b0;
      flags_q  <= '0;
    end else begin
      res_we <= wr_dest;
      if (wr_dest)                 res_data <= alu_result;
      if (commit && in_set_flags)  flags_q  <= flags_nx;
    end
  end
endmodule

// File: rtl/dp_alu_core_chk.sv
module dp_alu_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        in_opcode,
  input logic              in_set_flags,
  input logic              in_imm_form,
  input logic [3:0]        in_cond,
  input logic              cond_pass,
  input logic [DATA_W-1:0] res_data,
  input logic              res_we,
  input logic [3:0]        flags_q
);
  logic is_logic;
  assign is_logic = (in_opcode[3:1] == 3'b000) || (in_opcode[3:1] == 3'b100) ||
                    (in_opcode[3:2] == 2'b11);

  p_test_nowr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_opcode[3:2] == 2'b10 |=> !res_we && $stable(res_data));

  p_zn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_we && $past(in_set_flags) |->
      flags_q[2] == (res_data == '0) && flags_q[3] == res_data[DATA_W-1]);

  p_logic_keepv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_logic |=> flags_q[0] == $past(flags_q[0]));

  p_logic_regc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_logic && !in_imm_form |=> flags_q[1] == $past(flags_q[1]));

  p_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cond == 4'hE && in_opcode[3:2] != 2'b10 |=> res_we);

  p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_cond == 4'hF |=> !res_we && $stable(flags_q));

  p_fail_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !cond_pass) |=> !res_we && $stable(flags_q) && $stable(res_data));

  p_noset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_set_flags |=> $stable(flags_q));
endmodule

bind dp_alu_core dp_alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_opcode    (in_opcode),
  .in_set_flags (in_set_flags),
  .in_imm_form  (in_imm_form),
  .in_cond      (in_cond),
  .cond_pass    (cond_pass),
  .res_data     (res_data),
  .res_we       (res_we),
  .flags_q      (flags_q)
);

// File: tb/dp_alu_core_tb.sv
`timescale 1ns/1ps
module dp_alu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_opcode = '0;
  logic        in_set_flags = 1'b0;
  logic        in_imm_form = 1'b0;
  logic [3:0]  in_cond = '0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic        in_imm_rot = 1'b0;
  logic        in_pc_sel = 1'b0;
  logic [31:0] in_pc = '0;
  logic [31:0] res_data;
  logic        res_we;
  logic [3:0]  flags_q;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_tag = "R11";

  // reference state: N,Z,C,V as separate bits
  bit          fn, fz, fc, fv;
  logic [31:0] m_res = '0;
  bit          m_we = 0;

  always #2.5 clk = ~clk;

  dp_alu_core u_dut (.*);

  task automatic check_outputs();
    checks += 3;
    if (res_we !== m_we) begin
      errors++; $display("FAIL %s res_we act=%0b exp=%0b", cur_tag, res_we, m_we);
    end
    if (res_data !== m_res) begin
      errors++; $display("FAIL %s res_data act=%h exp=%h", cur_tag, res_data, m_res);
    end
    if (flags_q !== {fn, fz, fc, fv}) begin
      errors++; $display("FAIL %s flags act=%b exp=%b", cur_tag, flags_q, {fn, fz, fc, fv});
    end
  endtask

  function automatic bit cond_ok(logic [3:0] cc);
    case (cc)
      4'd0:  return fz;
      4'd1:  return !fz;
      4'd2:  return fc;
      4'd3:  return !fc;
      4'd4:  return fn;
      4'd5:  return !fn;
      4'd6:  return fv;
      4'd7:  return !fv;
      4'd8:  return fc && !fz;
      4'd9:  return !fc || fz;
      4'd10: return fn == fv;
      4'd11: return fn != fv;
      4'd12: return !fz && (fn == fv);
      4'd13: return fz || (fn != fv);
      4'd14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic model(input bit v, input logic [3:0] op, input bit s, input bit imm,
                       input logic [3:0] cc, input logic [31:0] a, input logic [31:0] b,
                       input bit rot, input bit pcs, input logic [31:0] pc);
    logic [31:0] first, p, q, r;
    longint unsigned up, uq, br, wide;
    longint sp, sq, ideal;
    bit arith, nc, nv;
    m_we = 0;
    if (!v || !cond_ok(cc)) return;
    first = pcs ? pc + 32'd8 : a;
    if (op == 4'd3 || op == 4'd7) begin p = b; q = first; end
    else begin p = first; q = b; end
    up = {32'h0, p}; uq = {32'h0, q};
    sp = longint'($signed(p)); sq = longint'($signed(q));
    arith = 1; nc = fc; nv = fv;
    case (op)
      4'd0, 4'd8:  begin r = p & q; arith = 0; end
      4'd1, 4'd9:  begin r = p ^ q; arith = 0; end
      4'd12:       begin r = p | q; arith = 0; end
      4'd13:       begin r = b;     arith = 0; end
      4'd14:       begin r = p & ~q; arith = 0; end
      4'd15:       begin r = ~b;    arith = 0; end
      4'd4, 4'd5, 4'd11: begin
        br = (op == 4'd5) ? longint'(fc) : 0;
        wide = up + uq + br;
        r = wide[31:0];
        nc = wide > 64'hFFFF_FFFF;
        ideal = sp + sq + longint'(br);
      end
      default: begin
        br = (op == 4'd6 || op == 4'd7) ? longint'(!fc) : 0;
        r = p - q - br[31:0];
        nc = up >= uq + br;
        ideal = sp - sq - longint'(br);
      end
    endcase
    if (arith) nv = (ideal > 64'sd2147483647) || (ideal < -64'sd2147483648);
    else if (imm && (rot || b > 32'd255)) nc = b[31];
    if (op[3:2] != 2'b10) begin m_we = 1; m_res = r; end
    if (s) begin fn = r[31]; fz = (r == 0); fc = nc; fv = nv; end
  endtask

  task automatic issue(input bit v, input logic [3:0] op, input bit s, input bit imm,
                       input logic [3:0] cc, input logic [31:0] a, input logic [31:0] b,
                       input bit rot, input bit pcs, input logic [31:0] pc, input string tag);
    @(negedge clk);
    check_outputs();
    model(v, op, s, imm, cc, a, b, rot, pcs, pc);
    in_valid = v; in_opcode = op; in_set_flags = s; in_imm_form = imm; in_cond = cc;
    in_opa = a; in_opb = b; in_imm_rot = rot; in_pc_sel = pcs; in_pc = pc;
    cur_tag = tag;
  endtask

  // shorthand: valid, always-condition, register form, no pc
  task automatic op_al(input logic [3:0] op, input bit s, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    issue(1, op, s, 0, 4'hE, a, b, 0, 0, 32'h0, tag);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return $urandom % 300;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    fn = 0; fz = 0; fc = 0; fv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_tag = "R11";
    check_outputs();            // R11 reset state
    rst_n = 1'b1;

    // R1 result functions
    op_al(4'h0, 0, 32'hF0F0_00FF, 32'h0FF0_FF0F, "R1");
    op_al(4'h1, 0, 32'hF0F0_00FF, 32'h0FF0_FF0F, "R1");
    op_al(4'hC, 0, 32'hF0F0_00FF, 32'h0FF0_FF0F, "R1");
    op_al(4'hE, 0, 32'hF0F0_00FF, 32'h0FF0_FF0F, "R1");
    op_al(4'hD, 0, 32'h1234_5678, 32'hCAFE_0001, "R1");
    op_al(4'hF, 0, 32'h1234_5678, 32'hCAFE_0001, "R1");
    op_al(4'h2, 0, 32'd100, 32'd58, "R1");
    // R6 N and Z
    op_al(4'hD, 1, 32'h0, 32'h8000_0000, "R6");
    op_al(4'hD, 1, 32'h0, 32'h0, "R6");
    // R4 carry out and borrow
    op_al(4'h4, 1, 32'hFFFF_FFFF, 32'h1, "R4");
    op_al(4'h2, 1, 32'd3, 32'd5, "R4");
    op_al(4'h6, 1, 32'h5, 32'hFFFF_FFFF, "R4");   // C clear: borrow makes C stay 0
    // R5 overflow
    op_al(4'h4, 1, 32'h7FFF_FFFF, 32'h1, "R5");
    op_al(4'h2, 1, 32'h8000_0000, 32'h1, "R5");
    op_al(4'h2, 1, 32'h1, 32'h2, "R5");
    // R3 carry-in, reversal
    op_al(4'hA, 1, 32'd5, 32'd3, "R3");          // sets C
    op_al(4'h5, 0, 32'd10, 32'd20, "R3");
    op_al(4'h3, 0, 32'd5, 32'd3, "R3");
    op_al(4'hA, 1, 32'd3, 32'd5, "R3");          // clears C
    op_al(4'h6, 1, 32'd10, 32'd4, "R3");
    op_al(4'h7, 1, 32'd4, 32'd10, "R3");
    // R2 tests write nothing
    op_al(4'h8, 1, 32'hFF, 32'h0F, "R2");
    op_al(4'h9, 1, 32'hFF, 32'hFF, "R2");
    op_al(4'hB, 1, 32'hFFFF_FFFF, 32'h1, "R2");
    // R7 logical carry and overflow rules
    op_al(4'h4, 1, 32'h7FFF_FFFF, 32'h1, "R7");  // V=1
    issue(1, 4'hC, 1, 1, 4'hE, 32'h1, 32'h8000_0000, 0, 0, 0, "R7");
    issue(1, 4'hC, 1, 1, 4'hE, 32'h1, 32'h0000_0010, 1, 0, 0, "R7");
    issue(1, 4'hC, 1, 1, 4'hE, 32'h1, 32'h8000_0000, 0, 0, 0, "R7");
    issue(1, 4'hC, 1, 1, 4'hE, 32'h1, 32'h0000_0020, 0, 0, 0, "R7");
    op_al(4'h0, 1, 32'hFFFF_FFFF, 32'h0, "R7");
    // R8 every condition code under two flag states
    op_al(4'hA, 1, 32'd5, 32'd5, "R8");          // Z=1 C=1
    for (int c = 0; c < 16; c++) issue(1, 4'hD, 0, 0, 4'(c), 0, 32'(c + 16), 0, 0, 0, "R8");
    op_al(4'hA, 1, 32'h8000_0000, 32'h1, "R8");  // N=0 V=1 C=1
    for (int c = 0; c < 16; c++) issue(1, 4'hD, 0, 0, 4'(c), 0, 32'(c + 48), 0, 0, 0, "R8");
    // R9 no commit
    issue(0, 4'h4, 1, 0, 4'hE, 32'h1, 32'h2, 0, 0, 0, "R9");
    issue(1, 4'h2, 1, 0, 4'hF, 32'h9, 32'h2, 0, 0, 0, "R9");
    op_al(4'h4, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9");
    // R10 pc operand
    issue(1, 4'h4, 0, 0, 4'hE, 32'h5, 32'h4, 0, 1, 32'h0000_1000, "R10");
    issue(1, 4'h3, 1, 0, 4'hE, 32'h5, 32'h2000, 0, 1, 32'h0000_1000, "R10");

    for (int i = 0; i < 4000; i++)
      issue(($urandom % 8) != 0, 4'($urandom), 1'($urandom), 1'($urandom),
            (($urandom % 3) == 0) ? 4'hE : 4'($urandom), pick(), pick(),
            (($urandom % 4) == 0), (($urandom % 6) == 0), $urandom & 32'hFFFF_FFFC, "R1");

    issue(0, 4'h0, 0, 0, 4'hE, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule